// File: doc/BRIEF.md
# Programmable Waveform Sequencer

The block is a small state machine whose behaviour comes entirely from a 32-byte descriptor table. The table is loaded through a byte-wide write port. It describes seven active states, numbered 0 to 6, and an idle state 7. A one-cycle start pulse launches a run from state 0. The run ends when the machine reaches the idle state, and a done level is then raised.

Each active state is one of two kinds:

- A timed state stays in place for a programmed number of clock cycles, then moves on to the next state number.
- A decision state spends one cycle evaluating a programmable two-input logic function over selectable flags, then jumps to one of two programmed targets.

Any state may ask for the parallel data bus to be captured in each of its cycles. Every state drives a byte of control pins.

A typical use is a capture loop. A sampling state alternates with a decision state that tests the FIFO flag. The loop runs until the FIFO reports full and then parks in idle.

Top module: `wseq_top`

## Requirements
- R1: After reset the machine is idle, `done` is 0, `cap_strobe` is 0 and every table byte is 0, so `ctl_out` reads 0.
- R2: A write with `cfg_we` high stores `cfg_wdata` at table byte `cfg_addr`. The table has four 8-byte groups: bytes 0-7 hold length/branch, 8-15 hold opcode, 16-23 hold output, and 24-31 hold logic function. Byte N%8 of each group belongs to state N%8. While idle, `ctl_out` equals byte 23.
- R3: A `start` pulse seen in idle enters state 0 on the next edge and clears `done`. A `start` seen in any other state has no effect.
- R4: In a timed state (opcode bit 0 = 0), the length/branch byte L gives the number of cycles spent there, with L = 0 meaning 256. The next state is the current state plus one, so a timed state 6 leads to idle.
- R5: A decision state (opcode bit 0 = 1) lasts one cycle. It then goes to length/branch bits 5:3 when the condition is 1, or to bits 2:0 when it is 0. A target of 7 means idle.
- R6: When bit 7 of a decision state's length/branch byte is set, the state runs one extra cycle on itself before it takes its branch.
- R7: Logic-function byte encoding:
  - Bits 7:6 pick the function: 00 = A AND B, 01 = A OR B, 10 = A XOR B, 11 = A AND NOT B.
  - Bits 5:3 select operand A and bits 2:0 select operand B.
  - Selector values 0-5 pick `flags_in[0..5]`, 6 picks the FIFO flag, and 7 is a constant 1.
  - The byte is ignored in timed states.
- R8: The FIFO flag is `fifo_full` when `fifo_sel` = 1 and `fifo_empty` when `fifo_sel` = 0. The input that is not selected does not affect branching.
- R9: For each cycle spent in a state whose opcode bit 1 is set, `cap_strobe` is high in the following cycle. In that cycle `cap_data` holds `data_in` as sampled at the edge that ended the sampling cycle.
- R10: `ctl_out` equals the output byte of the current state for every cycle the state is held.
- R11: `done` rises on the edge that enters idle from a run and stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | interface clock |
| rst_n | input | 1 | active-low synchronous reset |
| cfg_we | input | 1 | table byte write enable |
| cfg_addr | input | 5 | table byte address |
| cfg_wdata | input | 8 | table byte write data |
| fifo_sel | input | 1 | FIFO flag choice: 1 full, 0 empty |
| start | input | 1 | launch pulse |
| data_in | input | DATA_W (8) | parallel data bus |
| flags_in | input | NFLAG (6) | general ready/flag inputs |
| fifo_full | input | 1 | FIFO full flag |
| fifo_empty | input | 1 | FIFO empty flag |
| cap_strobe | output | 1 | capture strobe |
| cap_data | output | DATA_W (8) | captured data word |
| ctl_out | output | 8 | per-state control pins |
| done | output | 1 | run finished |

## Verification
State changes and `done` appear one edge after the cycle that causes them. A capture appears on `cap_strobe`/`cap_data` one edge after its sampling cycle. `ctl_out` follows the current state with no extra delay.

The bench drives inputs at the falling edge and reads outputs 1 ns after the rising edge. It counts edges from the one that accepted `start`, which it calls E0. Each expected value is placed at a known edge, for example:

- In the capture loop, strobes appear after the odd edges.
- In the long-run waveform, state 1 occupies edges E3 to E258.
- The re-executed decision state holds through E260.
- Idle is reached at E261, E263 or E264, depending on the flags.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
  localparam int ST_W    = 3;
  localparam int NGROUP  = 4;
  localparam int NSLOT   = 1 << ST_W;
  localparam int TBL_N   = NGROUP * NSLOT;
  localparam int ADDR_W  = $clog2(TBL_N);
  localparam int CNT_W   = 9;
  localparam logic [ST_W-1:0] ST_IDLE = '1;

  typedef enum logic [1:0] {
    LF_AND  = 2'b00,
    LF_OR   = 2'b01,
    LF_XOR  = 2'b10,
    LF_ANDN = 2'b11
  } lfunc_e;

  // dwell length of a timed state; zero stands for 256
  function automatic logic [CNT_W-1:0] dwell_len(input logic [7:0] lb);
    dwell_len = (lb == 8'd0) ? 9'd256 : {1'b0, lb};
  endfunction

  function automatic logic lfunc_apply(input lfunc_e fn, input logic a, input logic b);
    case (fn)
      LF_AND:  lfunc_apply = a & b;
      LF_OR:   lfunc_apply = a | b;
      LF_XOR:  lfunc_apply = a ^ b;
      default: lfunc_apply = a & ~b;
    endcase
  endfunction
endpackage

// File: rtl/wseq_table.sv
module wseq_table
  import wseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ST_W-1:0]   st,
  output logic [7:0]        lb_byte,
  output logic [7:0]        op_byte,
  output logic [7:0]        out_byte,
  output logic [7:0]        lf_byte,
  output logic [7:0]        idle_out
);
  logic [7:0] grp [NGROUP][NSLOT];

  for (genvar g = 0; g < NGROUP; g++) begin : g_grp
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) grp[g][s] <= '0;
        else if (we && waddr == ADDR_W'(g * NSLOT + s)) grp[g][s] <= wdata;
      end
    end
  end

  assign lb_byte  = grp[0][st];
  assign op_byte  = grp[1][st];
  assign out_byte = grp[2][st];
  assign lf_byte  = grp[3][st];
  assign idle_out = grp[2][ST_IDLE];
endmodule

// File: rtl/wseq_cond.sv
module wseq_cond
  import wseq_pkg::*;
(
  input  logic [7:0] lf_byte,
  input  logic [7:0] flag_vec,
  output logic       cond
);
  logic opa, opb;
  assign opa  = flag_vec[lf_byte[5:3]];
  assign opb  = flag_vec[lf_byte[2:0]];
  assign cond = lfunc_apply(lfunc_e'(lf_byte[7:6]), opa, opb);
endmodule

// File: rtl/wseq_top.sv
module wseq_top
  import wseq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NFLAG  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [4:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              fifo_sel,
  input  logic              start,
  input  logic [DATA_W-1:0] data_in,
  input  logic [NFLAG-1:0]  flags_in,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  output logic              cap_strobe,
  output logic [DATA_W-1:0] cap_data,
  output logic [7:0]        ctl_out,
  output logic              done
);
  localparam int FIFO_SELV = NFLAG;

  logic [ST_W-1:0]  st_cur, st_nxt;
  logic [CNT_W-1:0] dwell_cnt;
  logic             rex_used;
  logic [7:0]       lb_byte, op_byte, out_byte, lf_byte, idle_out;
  logic [7:0]       flag_vec;
  logic             cond;

  // named events for the checker
  logic st_idle, is_dec, samp_now, launch, dwell_end, rex_hold;

  wseq_table u_tbl (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .st(st_cur), .lb_byte(lb_byte), .op_byte(op_byte), .out_byte(out_byte),
    .lf_byte(lf_byte), .idle_out(idle_out)
  );

  always_comb begin
    flag_vec = '0;
    flag_vec[NFLAG-1:0] = flags_in;
    flag_vec[FIFO_SELV] = fifo_sel ? fifo_full : fifo_empty;
    flag_vec[7]         = 1'b1;
  end

  wseq_cond u_cond (.lf_byte(lf_byte), .flag_vec(flag_vec), .cond(cond));

  assign st_idle   = (st_cur == ST_IDLE);
  assign is_dec    = !st_idle && op_byte[0];
  assign samp_now  = !st_idle && op_byte[1];
  assign launch    = st_idle && start;
  assign dwell_end = !st_idle && !op_byte[0] &&
                     ((dwell_cnt + CNT_W'(1)) == dwell_len(lb_byte));
  assign rex_hold  = is_dec && lb_byte[7] && !rex_used;

  always_comb begin
    st_nxt = st_cur;
    if (launch)                   st_nxt = '0;
    else if (is_dec && !rex_hold) st_nxt = cond ? lb_byte[5:3] : lb_byte[2:0];
    else if (dwell_end)           st_nxt = st_cur + ST_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_cur     <= ST_IDLE;
      dwell_cnt  <= '0;
      rex_used   <= 1'b0;
      done       <= 1'b0;
      cap_strobe <= 1'b0;
      cap_data   <= '0;
    end else begin
      cap_strobe <= samp_now;
      if (samp_now) cap_data <= data_in;
      st_cur <= st_nxt;
      if (launch) begin
        dwell_cnt <= '0;
        rex_used  <= 1'b0;
        done      <= 1'b0;
      end else if (!st_idle) begin
        if (is_dec) begin
          dwell_cnt <= '0;
          rex_used  <= rex_hold;
        end else if (dwell_end) begin
          dwell_cnt <= '0;
        end else begin
          dwell_cnt <= dwell_cnt + CNT_W'(1);
        end
        if (st_nxt == ST_IDLE) done <= 1'b1;
      end
    end
  end

  assign ctl_out = st_idle ? idle_out : out_byte;
endmodule

// File: rtl/wseq_chk.sv
module wseq_chk
  import wseq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             st_idle,
  input logic [ST_W-1:0]  st_cur,
  input logic             samp_now,
  input logic             cap_strobe,
  input logic             done,
  input logic             rex_hold,
  input logic [7:0]       ctl_out,
  input logic [7:0]       idle_out,
  input logic [CNT_W-1:0] dwell_cnt
);
  a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && start) |=> (st_cur == '0 && !done));

  a_r9_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |-> $past(samp_now));

  a_r11_done_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> st_idle);

  a_r11_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(!st_idle));

  a_r6_rex_stays: assert property (@(posedge clk) disable iff (!rst_n)
    rex_hold |=> (st_cur == $past(st_cur)));

  a_r2_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> (ctl_out == idle_out));

  a_r4_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> (dwell_cnt == '0));
endmodule

bind wseq_top wseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .st_idle(st_idle), .st_cur(st_cur),
  .samp_now(samp_now), .cap_strobe(cap_strobe), .done(done), .rex_hold(rex_hold),
  .ctl_out(ctl_out), .idle_out(idle_out), .dwell_cnt(dwell_cnt)
);

// File: tb/sim_wseq_top.sv
`timescale 1ns/1ps
module sim_wseq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       fifo_sel = 1'b1;
  logic       start = 1'b0;
  logic [7:0] data_in = '0;
  logic [5:0] flags_in = '0;
  logic       fifo_full = 1'b0;
  logic       fifo_empty = 1'b0;
  logic       cap_strobe;
  logic [7:0] cap_data;
  logic [7:0] ctl_out;
  logic       done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wseq_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .fifo_sel(fifo_sel), .start(start), .data_in(data_in),
    .flags_in(flags_in), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .cap_strobe(cap_strobe), .cap_data(cap_data), .ctl_out(ctl_out), .done(done)
  );

  // {wave id, byte address, byte value}; wave 0 = capture loop, wave 1 = long run
  localparam int NVEC = 30;
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b0, 5'd0,  8'h01}, {1'b0, 5'd1,  8'h38}, {1'b0, 5'd8,  8'h02},
    {1'b0, 5'd9,  8'h01}, {1'b0, 5'd16, 8'h11}, {1'b0, 5'd17, 8'h22},
    {1'b0, 5'd23, 8'hA5}, {1'b0, 5'd25, 8'h36}, {1'b0, 5'd24, 8'hC0},
    {1'b1, 5'd0,  8'h03}, {1'b1, 5'd1,  8'h00}, {1'b1, 5'd2,  8'hBC},
    {1'b1, 5'd4,  8'h01}, {1'b1, 5'd5,  8'h3E}, {1'b1, 5'd6,  8'h01},
    {1'b1, 5'd8,  8'h00}, {1'b1, 5'd9,  8'h02}, {1'b1, 5'd10, 8'h01},
    {1'b1, 5'd12, 8'h00}, {1'b1, 5'd13, 8'h01}, {1'b1, 5'd14, 8'h00},
    {1'b1, 5'd16, 8'h01}, {1'b1, 5'd17, 8'h02}, {1'b1, 5'd18, 8'h03},
    {1'b1, 5'd20, 8'h04}, {1'b1, 5'd21, 8'h05}, {1'b1, 5'd22, 8'h06},
    {1'b1, 5'd23, 8'h5A}, {1'b1, 5'd26, 8'h41}, {1'b1, 5'd29, 8'hF2}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(input logic wave);
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][13] == wave) begin
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = VEC[i][12:8]; cfg_wdata = VEC[i][7:0];
      end
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drives start so that the next rising edge (E0) accepts it
  task automatic launch();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int nstb;
    edges(3);
    @(negedge clk) rst_n = 1'b1;
    edges(1);
    check("R1 done", done, 0);
    check("R1 strobe", cap_strobe, 0);
    check("R1 ctl", ctl_out, 8'h00);

    // capture loop waveform
    load(1'b0);
    #1 check("R2 idle pins byte 23", ctl_out, 8'hA5);
    fifo_sel = 1'b1; fifo_full = 1'b0; fifo_empty = 1'b1;
    launch();
    check("R3 enter state 0", ctl_out, 8'h11);
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk) data_in = 8'(k);
      @(posedge clk); #1;
      check("R9 strobe cadence", cap_strobe, k % 2);
      if (k % 2 == 1) check("R9 captured word", cap_data, k);
      check("R10 per-state pins", ctl_out, (k % 2 == 1) ? 8'h22 : 8'h11);
      check("R5 R7 loop continues", done, 0);
    end
    @(negedge clk) fifo_full = 1'b1;
    edges(1);
    check("R5 decision state reached", ctl_out, 8'h22);
    edges(1);
    check("R7 AND on FIFO flag ends run", done, 1);
    check("R2 idle pins", ctl_out, 8'hA5);
    check("R9 no strobe in decision", cap_strobe, 0);
    edges(1);
    check("R11 done held", done, 1);
    check("R9 no strobe in idle", cap_strobe, 0);

    // long-run waveform; empty flag selected, full flag is a distractor
    load(1'b1);
    fifo_sel = 1'b0; fifo_empty = 1'b1; fifo_full = 1'b0; flags_in = '0;
    launch();
    check("R11 done cleared by start", done, 0);
    check("R4 state 0 pins", ctl_out, 8'h01);
    @(negedge clk) start = 1'b1;
    edges(1);
    check("R4 state 0 held E1", ctl_out, 8'h01);
    edges(1);
    check("R4 state 0 held E2", ctl_out, 8'h01);
    @(negedge clk) start = 1'b0;
    edges(1);
    check("R3 busy start ignored", ctl_out, 8'h02);
    nstb = 0;
    for (int i = 0; i < 256; i++) begin
      @(posedge clk); #1;
      if (cap_strobe) nstb++;
      if (i == 254) check("R4 len 0 still in state 1 at E258", ctl_out, 8'h02);
    end
    check("R4 len 0 means 256 cycles", ctl_out, 8'h03);
    check("R9 one strobe per sampling cycle", nstb, 256);
    edges(1);
    check("R6 re-execute holds", ctl_out, 8'h03);
    edges(1);
    check("R5 false branch to 4", ctl_out, 8'h04);
    edges(1);
    check("R4 next state number", ctl_out, 8'h05);
    edges(1);
    check("R7 A AND NOT B on FIFO empty", done, 1);
    check("R2 idle pins after run", ctl_out, 8'h5A);

    // true branch of the re-executing decision
    flags_in = 6'b000001;
    launch();
    edges(260);
    check("R6 re-execute before true branch", ctl_out, 8'h03);
    edges(1);
    check("R7 OR on flags true to idle", done, 1);
    check("R5 true target idle", ctl_out, 8'h5A);

    // full flag high but not selected: state 5 takes false branch to state 6
    flags_in = '0; fifo_empty = 1'b0; fifo_full = 1'b1;
    launch();
    edges(263);
    check("R8 unselected full ignored", ctl_out, 8'h06);
    check("R8 not yet done", done, 0);
    edges(1);
    check("R4 timed state 6 leads to idle", done, 1);

    rst_n = 1'b0;
    edges(1);
    #1 rst_n = 1'b1;
    check("R1 table cleared by reset", ctl_out, 8'h00);
    check("R1 done cleared by reset", done, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule